// File: doc/BRIEF.md
# Edge-Triggered Delayed Serial Transmitter

The block watches a slow reference clock that arrives without any timing relationship to the system clock. When the chosen edge of that reference is seen, it waits a programmable number of microseconds and then sends one framed word on a single serial line. Software or a neighbouring block loads the word in advance through a parallel port and a strobe. The block never starts a frame on its own or on a local request. Only a reference edge starts one.

Time is counted in microsecond ticks. A prescaler makes one tick from every `TICK_DIV` system clock cycles, so the delay count and every bit period are whole numbers of ticks. The reference input goes through a two-flop synchroniser. The edge is found by comparing the synchronised value with its registered copy. A parameter chooses whether rising or falling edges trigger. While a delay or a frame is in progress, the block ignores both new reference edges and new loads.

Top module: `edge_delay_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ser_out` is 1 and `busy` is 0.
- R2: If `ref_in` changes just after a clock edge, `busy` rises after the third rising clock edge that follows. The input is sampled by two flops and the edge is detected in the cycle after that.
- R3: Only the edge selected by `RISE_EDGE` triggers a frame (1 = low-to-high, 0 = high-to-low). An edge of the other direction leaves `busy` at 0 and `ser_out` at 1.
- R4: After the trigger, `ser_out` stays at 1 for `n * TICK_DIV` cycles, where `n` is the value of `delay_n` sampled at the trigger edge.
- R5: A frame is a start bit of 0, then the `DATA_W` data bits with the least significant bit first, then one stop bit of 1. Each bit lasts `TICK_DIV` cycles.
- R6: `busy` is 1 from the cycle after the trigger until the stop bit ends. It then returns to 0 and `ser_out` rests at 1.
- R7: A selected reference edge that arrives while `busy` is 1 does not restart or extend the frame in progress and starts no second frame.
- R8: With `n` = 0, the start bit appears in the first cycle after the trigger edge, which is the same cycle in which `busy` rises.
- R9: A pulse on `load_stb` while `busy` is 0 stores `load_data` for the next frame. A pulse while `busy` is 1 is ignored, and the following frame still carries the previously stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ref_in | input | 1 | Slow reference clock, asynchronous |
| delay_n | input | DLY_W | Delay before the frame, in microsecond ticks |
| load_data | input | DATA_W | Word for the next frame |
| load_stb | input | 1 | Stores `load_data` while idle |
| ser_out | output | 1 | Serial line, idle high |
| busy | output | 1 | A delay or a frame is in progress |

## Verification
The hardest case to reach is a reference edge or a load that lands inside a frame already running. Only that stimulus shows whether the block really ignores it, or whether it quietly restarts the delay or corrupts the word being sent. The stimulus therefore toggles the reference several times and pulses the load strobe with a different word during both the delay phase and the shift phase. It then sends one more frame to show that the earlier word was kept. A zero delay and a reference edge of the wrong direction are also driven, so the trigger boundary is checked from both sides.

// File: rtl/edt_pkg.sv
package edt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } edt_state_t;
endpackage

// File: rtl/edt_edge_sync.sv
module edt_edge_sync #(
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_pulse
);
   logic meta_q, sync_q, prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= async_in;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   generate
      if (RISE_EDGE) begin : g_rise
         assign edge_pulse = sync_q & ~prev_q;
      end else begin : g_fall
         assign edge_pulse = ~sync_q & prev_q;
      end
   endgenerate
endmodule

// File: rtl/edt_tick_gen.sv
module edt_tick_gen #(
   parameter int TICK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               cnt_q <= '0;
            end else if (cnt_q == TOP) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = (cnt_q == TOP);
      end
   endgenerate
endmodule

// File: rtl/edt_frame_ctrl.sv
module edt_frame_ctrl
   import edt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DLY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              tick,
   input  logic [DLY_W-1:0]  delay_n,
   input  logic [DATA_W-1:0] word,
   output logic              restart,
   output logic              ser_out,
   output logic              busy
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   edt_state_t         st_q;
   logic [DLY_W-1:0]   dcnt_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [BIT_W-1:0]   bcnt_q;

   assign restart = (st_q == ST_IDLE) && trig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dcnt_q  <= '0;
         shreg_q <= '1;
         bcnt_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (trig) begin
                  shreg_q <= {1'b1, word, 1'b0};
                  bcnt_q  <= '0;
                  dcnt_q  <= delay_n;
                  st_q    <= (delay_n == '0) ? ST_SHIFT : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tick) begin
                  if (dcnt_q == DLY_W'(1)) st_q <= ST_SHIFT;
                  else                     dcnt_q <= dcnt_q - 1'b1;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (bcnt_q == LAST_BIT) begin
                     st_q    <= ST_IDLE;
                     shreg_q <= '1;
                  end else begin
                     shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                     bcnt_q  <= bcnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ser_out = (st_q == ST_SHIFT) ? shreg_q[0] : 1'b1;
   assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/edge_delay_tx.sv
module edge_delay_tx #(
   parameter int DATA_W    = 8,
   parameter int DLY_W     = 8,
   parameter int TICK_DIV  = 125,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic [DLY_W-1:0]  delay_n,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_stb,
   output logic              ser_out,
   output logic              busy
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dly_w
         $error("DLY_W must be at least 1");
      end
      if (TICK_DIV < 1) begin : g_bad_tick_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic              edge_evt;
   logic              tick;
   logic              restart;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  hold_q <= '0;
      else if (load_stb && !busy)  hold_q <= load_data;
   end

   edt_edge_sync #(.RISE_EDGE(RISE_EDGE)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (ref_in),
      .edge_pulse (edge_evt)
   );

   edt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   edt_frame_ctrl #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (edge_evt),
      .tick    (tick),
      .delay_n (delay_n),
      .word    (hold_q),
      .restart (restart),
      .ser_out (ser_out),
      .busy    (busy)
   );
endmodule

// File: rtl/edt_checker.sv
module edt_checker #(
   parameter int DATA_W   = 8,
   parameter int DLY_W    = 8,
   parameter int TICK_DIV = 125
) (
   input logic             clk,
   input logic             rst_n,
   input logic             edge_evt,
   input logic [DLY_W-1:0] delay_n,
   input logic             ser_out,
   input logic             busy
);
   localparam int MAX_BUSY = ((2**DLY_W) - 1) * TICK_DIV + (DATA_W + 2) * TICK_DIV;

   int busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_run <= 0;
      else                 busy_run <= busy_run + 1;
   end

   // R6: line rests high whenever nothing is in progress
   p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser_out);

   // R2: busy rises only after a detected reference edge
   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(edge_evt));

   // R8: zero delay puts the start bit out together with busy
   p_zero_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(delay_n) == '0) |-> !ser_out);

   // R5: the last bit before busy falls is the stop bit
   p_stop_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(ser_out));

   // R7: a frame is never extended past its longest legal length
   p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= MAX_BUSY);
endmodule

bind edge_delay_tx edt_checker #(
   .DATA_W   (DATA_W),
   .DLY_W    (DLY_W),
   .TICK_DIV (TICK_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .edge_evt (edge_evt),
   .delay_n  (delay_n),
   .ser_out  (ser_out),
   .busy     (busy)
);

// File: tb/tb_edge_delay_tx.sv
module tb_edge_delay_tx;
   localparam int DATA_W   = 8;
   localparam int DLY_W    = 6;
   localparam int TICK_DIV = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_in = 1'b0;
   logic [DLY_W-1:0]  delay_n = '0;
   logic [DATA_W-1:0] load_data = '0;
   logic              load_stb = 1'b0;
   logic              ser_out, busy;

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit    m_s1 = 0, m_s2 = 0, m_prev = 0, m_busy = 0;
   logic [DATA_W-1:0] m_hold = '0;
   bit    m_q[$];

   always #4 clk = ~clk;

   edge_delay_tx #(.DATA_W(DATA_W), .DLY_W(DLY_W), .TICK_DIV(TICK_DIV), .RISE_EDGE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .delay_n(delay_n),
      .load_data(load_data), .load_stb(load_stb), .ser_out(ser_out), .busy(busy));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_busy = 0; m_hold = '0; m_q.delete();
      end else begin
         bit det, was_busy;
         det = m_s2 & ~m_prev;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = ref_in;
         was_busy = m_busy;
         if (was_busy) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) m_busy = 0;
         end else begin
            if (det) begin
               for (int i = 0; i < int'(delay_n) * TICK_DIV; i++) m_q.push_back(1'b1);
               for (int b = 0; b < DATA_W + 2; b++) begin
                  bit v;
                  v = (b == 0) ? 1'b0 : (b == DATA_W + 1) ? 1'b1 : m_hold[b-1];
                  for (int k = 0; k < TICK_DIV; k++) m_q.push_back(v);
               end
               m_busy = 1;
            end
            if (load_stb) m_hold = load_data;
         end
      end
   end

   task automatic chk(input bit got, input bit exp, input string what);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(busy, m_busy, "busy");
         chk(ser_out, m_busy ? m_q[0] : 1'b1, "ser_out");
      end
   end

   task automatic load(input logic [DATA_W-1:0] d);
      @(negedge clk); load_data = d; load_stb = 1'b1;
      @(negedge clk); load_stb = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (4) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic frame(input logic [DLY_W-1:0] n);
      @(negedge clk); delay_n = n; ref_in = 1'b1;
      wait_idle();
      ref_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(ser_out, 1'b1, "ser_out in reset");
      chk(busy, 1'b0, "busy in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(ser_out, 1'b1, "ser_out after reset");
      chk(busy, 1'b0, "busy after reset");

      // R2 R4 R5 R6: basic frame with delay
      cur_req = "R4";
      load(8'hA5);
      frame(6'd3);
      cur_req = "R5";
      load(8'h81);
      frame(6'd1);

      // R2: exact trigger latency
      cur_req = "R2";
      @(negedge clk); delay_n = 6'd2; ref_in = 1'b1;
      @(negedge clk); chk(busy, 1'b0, "edge plus 1");
      @(negedge clk); chk(busy, 1'b0, "edge plus 2");
      @(negedge clk); chk(busy, 1'b1, "edge plus 3");
      cur_req = "R6";
      wait_idle();
      ref_in = 1'b0;
      repeat (6) @(negedge clk);

      // R3: falling edge ignored (ref already low now; raise slowly then drop while idle)
      cur_req = "R3";
      ref_in = 1'b1;
      wait_idle();
      ref_in = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy, 1'b0, "no frame on falling edge");

      // R8: zero delay
      cur_req = "R8";
      load(8'h3C);
      frame(6'd0);
      load(8'hFF);
      frame(6'd0);

      // R7 R9: reference toggles and loads during a frame
      cur_req = "R7";
      load(8'h5A);
      @(negedge clk); delay_n = 6'd5; ref_in = 1'b1;
      repeat (8) @(negedge clk);
      cur_req = "R9";
      load(8'hC3);
      cur_req = "R7";
      for (int i = 0; i < 6; i++) begin
         repeat (7) @(negedge clk); ref_in = ~ref_in;
      end
      cur_req = "R9";
      load(8'h0F);
      wait_idle();
      ref_in = 1'b0;
      repeat (6) @(negedge clk);
      frame(6'd2);

      // R4: long delay
      cur_req = "R4";
      load(8'h69);
      frame(6'd63);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule